// File: doc/BRIEF.md
# Mesh Dimension-Order Route Unit

This block is the route-computation stage of one router in a two-dimensional mesh. When a head flit arrives it compares the packet's destination coordinates with the router's own coordinates. It then picks one of five output ports (local, east, west, north, south) and the virtual-channel class the packet continues on. The chosen route is registered and held for the whole packet. It is released when the tail flit passes, so the body flits follow the head through the same port.

Two channel classes exist. On the primary class (XY) a packet corrects its horizontal offset first and only then its vertical offset. This ordering removes the cyclic channel dependencies that would otherwise allow deadlock. A second class (YX) enforces vertical-first order. When the horizontal port that the XY route needs is flagged busy and the packet still has vertical distance to cover, the packet is moved onto the YX class and sent vertically. Once a packet is on the YX class it stays there at every later hop. The crossbar and the flit buffers sit outside this block.

The control is a two-state machine. In state IDLE no route is held. The transition ACCEPT (a head flit seen in IDLE) loads the computed route and enters HOLD. In HOLD the held route drives the outputs. The transition RELEASE (a tail flit seen in HOLD) clears the route and returns to IDLE. Every other input combination keeps the current state.

Top module: `mesh_dor_route_unit`

## Requirements
- R1: While reset is asserted, and after it is released until a head flit is accepted, route_valid is 0, route_port is 0 and route_cls is 0.
- R2: route_port is one-hot with bit 0 = local, bit 1 = east (+x), bit 2 = west (-x), bit 3 = north (+y), bit 4 = south (-y). Exactly one bit is set while route_valid is 1, and all bits are 0 while route_valid is 0. route_cls and in_cls use 0 = XY class and 1 = YX class.
- R3: If dst_x equals my_x and dst_y equals my_y, the route is the local port and route_cls equals in_cls.
- R4: On the XY class with dst_x different from my_x, the route is east if dst_x > my_x and west otherwise, with class XY. This holds when that port's xy_busy bit is 0, and also when dst_y equals my_y.
- R5: On the XY class with dst_x equal to my_x and dst_y different from my_y, the route is north if dst_y > my_y and south otherwise, with class XY.
- R6: On the XY class, if dst_x differs from my_x, the needed horizontal port's xy_busy bit is 1 and dst_y differs from my_y, the route is north or south (as in R5) with class YX.
- R7: On the YX class, a packet with dst_y different from my_y goes north or south. Otherwise it goes east or west (as in R4). route_cls is always YX, whatever the busy flags are.
- R8: A head flit sampled at a clock edge while no route is held makes route_valid 1, with the computed route, right after that same edge.
- R9: While a route is held, head flits and changes of dst_x, dst_y, in_cls and xy_busy leave route_port and route_cls unchanged. The edge that samples tail_flit clears route_valid and route_port.
- R10: A tail flit with no route held has no effect: route_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_flit | input | 1 | Head flit present this cycle |
| tail_flit | input | 1 | Tail flit present this cycle |
| dst_x | input | 3 | Destination X coordinate from the head flit |
| dst_y | input | 2 | Destination Y coordinate from the head flit |
| my_x | input | 3 | This router's X coordinate |
| my_y | input | 2 | This router's Y coordinate |
| in_cls | input | 1 | Class the packet arrived on (0 XY, 1 YX) |
| xy_busy | input | 5 | Per-output-port busy flags of the XY class, same bit order as route_port |
| route_valid | output | 1 | A route is held |
| route_port | output | 5 | One-hot selected output port |
| route_cls | output | 1 | Selected virtual-channel class |

## Verification
The route is due one clock edge after the head flit is sampled. It stays unchanged on every edge that does not sample a tail flit. It is cleared one edge after the tail flit. The bench drives each input just after a falling edge and lets exactly one rising edge pass. It then compares the outputs at the next falling edge against a route that a bench function computes from the requirements. Random hold lengths with noisy inputs between head and tail exercise R9. Directed cases cover the busy fallback with and without vertical distance, local delivery on the YX class, and a tail flit seen while idle.

// File: rtl/mesh_dor_route_pkg.sv
package mesh_dor_route_pkg;

    localparam int NPORT   = 5;
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;

    typedef enum logic {
        CLS_XY = 1'b0,
        CLS_YX = 1'b1
    } vc_cls_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rt_state_e;

    typedef struct packed {
        vc_cls_e              cls;
        logic [NPORT-1:0]     port;
    } route_t;

endpackage

// File: rtl/dor_route_calc.sv
module dor_route_calc
    import mesh_dor_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 2
) (
    input  logic [X_W-1:0]   dst_x,
    input  logic [Y_W-1:0]   dst_y,
    input  logic [X_W-1:0]   my_x,
    input  logic [Y_W-1:0]   my_y,
    input  vc_cls_e          in_cls,
    input  logic [NPORT-1:0] xy_busy,
    output route_t           result
);

    logic             x_done;
    logic             y_done;
    logic [NPORT-1:0] x_dir;
    logic [NPORT-1:0] y_dir;
    logic             x_blocked;

    always_comb begin
        x_done    = (dst_x == my_x);
        y_done    = (dst_y == my_y);
        x_dir     = (dst_x > my_x) ? (NPORT'(1) << P_EAST)  : (NPORT'(1) << P_WEST);
        y_dir     = (dst_y > my_y) ? (NPORT'(1) << P_NORTH) : (NPORT'(1) << P_SOUTH);
        x_blocked = |(xy_busy & x_dir);
    end

    always_comb begin
        result.cls  = in_cls;
        result.port = NPORT'(1) << P_LOCAL;
        if (x_done && y_done) begin
            result.cls  = in_cls;
            result.port = NPORT'(1) << P_LOCAL;
        end else if (in_cls == CLS_YX) begin
            result.cls  = CLS_YX;
            result.port = y_done ? x_dir : y_dir;
        end else if (!x_done) begin
            if (x_blocked && !y_done) begin
                result.cls  = CLS_YX;
                result.port = y_dir;
            end else begin
                result.cls  = CLS_XY;
                result.port = x_dir;
            end
        end else begin
            result.cls  = CLS_XY;
            result.port = y_dir;
        end
    end

endmodule

// File: rtl/dor_route_fsm.sv
module dor_route_fsm
    import mesh_dor_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   head_flit,
    input  logic   tail_flit,
    input  route_t calc_route,
    output logic   held_valid,
    output route_t held_route
);

    rt_state_e state_q;
    rt_state_e state_d;

    // next-state decision: ACCEPT and RELEASE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (head_flit) state_d = ST_HOLD;
            ST_HOLD: if (tail_flit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered route result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_route <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (head_flit) held_route <= calc_route;
                ST_HOLD: if (tail_flit) held_route <= '0;
                default: held_route <= '0;
            endcase
        end
    end

    assign held_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/mesh_dor_route_unit.sv
module mesh_dor_route_unit
    import mesh_dor_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_flit,
    input  logic             tail_flit,
    input  logic [X_W-1:0]   dst_x,
    input  logic [Y_W-1:0]   dst_y,
    input  logic [X_W-1:0]   my_x,
    input  logic [Y_W-1:0]   my_y,
    input  logic             in_cls,
    input  logic [NPORT-1:0] xy_busy,
    output logic             route_valid,
    output logic [NPORT-1:0] route_port,
    output logic             route_cls
);

    route_t calc_route;
    route_t held_route;

    dor_route_calc #(.X_W(X_W), .Y_W(Y_W)) u_calc (
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .my_x    (my_x),
        .my_y    (my_y),
        .in_cls  (vc_cls_e'(in_cls)),
        .xy_busy (xy_busy),
        .result  (calc_route)
    );

    dor_route_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_flit  (head_flit),
        .tail_flit  (tail_flit),
        .calc_route (calc_route),
        .held_valid (route_valid),
        .held_route (held_route)
    );

    assign route_port = held_route.port;
    assign route_cls  = held_route.cls;

endmodule

// File: rtl/dor_route_chk.sv
module dor_route_chk #(
    parameter int X_W = 3,
    parameter int Y_W = 2,
    parameter int NP  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           head_flit,
    input logic           tail_flit,
    input logic [X_W-1:0] dst_x,
    input logic [Y_W-1:0] dst_y,
    input logic [X_W-1:0] my_x,
    input logic [Y_W-1:0] my_y,
    input logic           in_cls,
    input logic [NP-1:0]  xy_busy,
    input logic           route_valid,
    input logic [NP-1:0]  route_port,
    input logic           route_cls
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> ($countones(route_port) == 1));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> (route_port == '0));

    p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(route_valid) && $past(dst_x == my_x) && $past(dst_y == my_y))
        |-> (route_port == NP'(1)) && (route_cls == $past(in_cls)));

    p_xy_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(route_valid) && !$past(in_cls) && $past(dst_x != my_x) && $past(xy_busy == '0))
        |-> ((route_port[1] || route_port[2]) && !route_cls));

    p_yx_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(route_valid) && $past(in_cls)) |-> route_cls);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !tail_flit) |=> (route_valid && $stable(route_port) && $stable(route_cls)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && tail_flit) |=> !route_valid);

    p_tail_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_valid && !head_flit) |=> !route_valid);

endmodule

bind mesh_dor_route_unit dor_route_chk #(.X_W(X_W), .Y_W(Y_W), .NP(5)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_flit   (head_flit),
    .tail_flit   (tail_flit),
    .dst_x       (dst_x),
    .dst_y       (dst_y),
    .my_x        (my_x),
    .my_y        (my_y),
    .in_cls      (in_cls),
    .xy_busy     (xy_busy),
    .route_valid (route_valid),
    .route_port  (route_port),
    .route_cls   (route_cls)
);

// File: tb/sim_mesh_dor_route_unit.sv
`timescale 1ns/1ps
module sim_mesh_dor_route_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       head_flit = 1'b0;
    logic       tail_flit = 1'b0;
    logic [2:0] dst_x = '0;
    logic [1:0] dst_y = '0;
    logic [2:0] my_x = '0;
    logic [1:0] my_y = '0;
    logic       in_cls = 1'b0;
    logic [4:0] xy_busy = '0;
    logic       route_valid;
    logic [4:0] route_port;
    logic       route_cls;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mesh_dor_route_unit u0 (
        .clk(clk), .rst_n(rst_n), .head_flit(head_flit), .tail_flit(tail_flit),
        .dst_x(dst_x), .dst_y(dst_y), .my_x(my_x), .my_y(my_y),
        .in_cls(in_cls), .xy_busy(xy_busy),
        .route_valid(route_valid), .route_port(route_port), .route_cls(route_cls)
    );

    // expected {cls, port}; port bits: 0 local, 1 east, 2 west, 3 north, 4 south
    function automatic logic [5:0] exp_route(input logic [2:0] dx, input logic [1:0] dy,
                                             input logic [2:0] mx, input logic [1:0] my,
                                             input logic cls, input logic [4:0] busy);
        logic [4:0] xp;
        logic [4:0] yp;
        xp = (dx > mx) ? 5'b00010 : 5'b00100;
        yp = (dy > my) ? 5'b01000 : 5'b10000;
        if (dx == mx && dy == my) return {cls, 5'b00001};
        if (cls) return {1'b1, (dy != my) ? yp : xp};
        if (dx == mx) return {1'b0, yp};
        if ((busy & xp) != 0 && dy != my) return {1'b1, yp};
        return {1'b0, xp};
    endfunction

    function automatic string req_tag(input logic [2:0] dx, input logic [1:0] dy,
                                      input logic [2:0] mx, input logic [1:0] my,
                                      input logic cls, input logic [4:0] busy);
        logic [5:0] e;
        e = exp_route(dx, dy, mx, my, cls, busy);
        if (dx == mx && dy == my) return "R3";
        if (cls) return "R7";
        if (e[5]) return "R6";
        if (dx != mx) return "R4";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: {valid,cls,port} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_packet(input logic [2:0] dx, input logic [1:0] dy,
                              input logic [2:0] mx, input logic [1:0] my,
                              input logic cls, input logic [4:0] busy, input int hold_n);
        logic [6:0] e;
        string tag;
        e = {1'b1, exp_route(dx, dy, mx, my, cls, busy)};
        tag = req_tag(dx, dy, mx, my, cls, busy);
        dst_x = dx; dst_y = dy; my_x = mx; my_y = my; in_cls = cls; xy_busy = busy;
        head_flit = 1'b1; tail_flit = 1'b0;
        step();
        head_flit = 1'b0;
        chk({route_valid, route_cls, route_port} == e, {tag, " R8 R2"},
            {route_valid, route_cls, route_port}, e);
        for (int i = 0; i < hold_n; i++) begin
            dst_x = 3'($urandom); dst_y = 2'($urandom);
            in_cls = 1'($urandom); xy_busy = 5'($urandom);
            head_flit = 1'($urandom);
            step();
            head_flit = 1'b0;
            chk({route_valid, route_cls, route_port} == e, "R9 hold",
                {route_valid, route_cls, route_port}, e);
        end
        tail_flit = 1'b1; head_flit = 1'($urandom);
        step();
        tail_flit = 1'b0; head_flit = 1'b0;
        chk({route_valid, route_port} == 6'b0, "R9 release R2",
            {route_valid, route_cls, route_port}, 7'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        step(); step();
        chk({route_valid, route_cls, route_port} == 7'b0, "R1 in reset",
            {route_valid, route_cls, route_port}, 7'b0);
        rst_n = 1'b1;
        step();
        chk({route_valid, route_cls, route_port} == 7'b0, "R1 after reset",
            {route_valid, route_cls, route_port}, 7'b0);

        // R10: tail while idle
        tail_flit = 1'b1;
        step();
        tail_flit = 1'b0;
        chk(route_valid == 1'b0, "R10 tail idle", {route_valid, route_cls, route_port}, 7'b0);

        // directed corners
        run_packet(3'd2, 2'd1, 3'd2, 2'd1, 1'b1, 5'b11111, 1); // R3 local keeps YX
        run_packet(3'd2, 2'd1, 3'd2, 2'd1, 1'b0, 5'b00000, 0); // R3 local on XY
        run_packet(3'd3, 2'd2, 3'd1, 2'd0, 1'b0, 5'b00010, 2); // R6 east busy -> north, YX
        run_packet(3'd0, 2'd0, 3'd1, 2'd2, 1'b0, 5'b00100, 1); // R6 west busy -> south, YX
        run_packet(3'd3, 2'd1, 3'd1, 2'd1, 1'b0, 5'b00010, 1); // R4 busy but no y distance
        run_packet(3'd0, 2'd3, 3'd3, 2'd0, 1'b0, 5'b00010, 0); // R4 west free
        run_packet(3'd1, 2'd0, 3'd1, 2'd3, 1'b0, 5'b00000, 0); // R5 south
        run_packet(3'd5, 2'd1, 3'd2, 2'd1, 1'b1, 5'b00000, 1); // R7 YX east when y done
        run_packet(3'd5, 2'd3, 3'd2, 2'd1, 1'b1, 5'b00000, 0); // R7 YX north first

        for (int p = 0; p < 400; p++) begin
            logic [2:0] mx;
            logic [1:0] my;
            logic [2:0] dx;
            logic [1:0] dy;
            mx = 3'($urandom_range(0, 3));
            my = 2'($urandom_range(0, 1));
            dx = ($urandom_range(0, 3) == 0) ? mx : 3'($urandom_range(0, 3));
            dy = ($urandom_range(0, 2) == 0) ? my : 2'($urandom_range(0, 1));
            run_packet(dx, dy, mx, my, 1'($urandom), 5'($urandom), int'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) begin
                tail_flit = 1'b1;
                step();
                tail_flit = 1'b0;
                chk(route_valid == 1'b0, "R10 tail idle",
                    {route_valid, route_cls, route_port}, 7'b0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule